// File: doc/BRIEF.md
# Transmit Delay and Line-Hold Timer

This block carries out a delay command that has been embedded in a transmit data stream. When such a command is accepted, the block loads the requested period into a down-counter. It then stops the character shifter from starting new work by raising an inhibit. It also takes over the serial line and drives it to a fixed level until the count runs out. That level is a break (low) or an inter-character fill (high), and the command picks which one.

The counter advances on an external tick pulse, so the delay is measured in whatever time base the channel supplies. Commands are honoured only while the channel has embedded transmit commands switched on. While a delay is running, the block raises `busy`, and any further command is left untaken. The source must hold its command until `busy` drops. The held command is then taken on the next clock edge.

Top module: `tx_delay_hold`

## Requirements
- R1: After reset, `busy`, `tx_inhibit` and `line_ovr_en` are 0 and `line_ovr_val` is 1.
- R2: While `emb_en` is 0, a `cmd_valid` strobe is not taken: `busy`, `tx_inhibit` and `line_ovr_en` stay 0.
- R3: A command taken with a nonzero `cmd_delay` raises `busy`, `tx_inhibit` and `line_ovr_en` in the first cycle after the accepting clock edge.
- R4: For a command with `cmd_brk` = 1 (break), `line_ovr_val` is 0 for the whole delay.
- R5: For a command with `cmd_brk` = 0 (fill), `line_ovr_val` is 1 for the whole delay.
- R6: Each clock cycle with `tick` high while a delay runs removes one unit from the count. Cycles without `tick` remove nothing. A `tick` in the accepting cycle is not counted.
- R7: After the Nth counted tick of an N-unit delay, `busy`, `tx_inhibit` and `line_ovr_en` all fall together in the next cycle, and `line_ovr_val` returns to 1.
- R8: A command with `cmd_delay` = 0 completes at once: `busy`, `tx_inhibit` and `line_ovr_en` never rise.
- R9: A command presented while `busy` is 1 is not taken and does not change the running delay or its line level. If it is held, it is taken on the first clock edge at which `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| emb_en | input | 1 | Embedded transmit commands enabled for the channel |
| cmd_valid | input | 1 | Delay command present |
| cmd_delay | input | CNT_W | Delay period in ticks |
| cmd_brk | input | 1 | 1 = hold line low (break), 0 = hold line high (fill) |
| tick | input | 1 | Time-base pulse, one count per cycle high |
| busy | output | 1 | Delay running; new commands held off |
| tx_inhibit | output | 1 | Blocks the shifter from starting a transmit |
| line_ovr_en | output | 1 | Line override active |
| line_ovr_val | output | 1 | Level forced onto the line |

## Verification
On every cycle, the assertions check the cycle-level rules. A taken command loads its count and raises the outputs. The count moves only on a tick and falls by one per tick. The held level does not change during a delay. Release follows the final tick. A busy or disabled block takes nothing. Only the bench scenarios can show the end-to-end timing. These cover every delay length for both line levels with idle gaps between ticks, the ignored tick in the accepting cycle, and a held second command taken exactly after the first delay ends.

// File: rtl/tx_delay_hold.sv
module tx_delay_hold #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             emb_en,
  input  logic             cmd_valid,
  input  logic [CNT_W-1:0] cmd_delay,
  input  logic             cmd_brk,
  input  logic             tick,
  output logic             busy,
  output logic             tx_inhibit,
  output logic             line_ovr_en,
  output logic             line_ovr_val
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic             active;
  logic             level;

  wire take = cmd_valid & emb_en & ~active;
  wire last = active & tick & (cnt == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
      level  <= 1'b1;
    end else if (take) begin
      cnt    <= cmd_delay;
      active <= |cmd_delay;
      level  <= ~cmd_brk;
    end else if (active && tick) begin
      cnt <= cnt - ONE;
      if (last) active <= 1'b0;
    end
  end

  assign busy         = active;
  assign tx_inhibit   = active;
  assign line_ovr_en  = active;
  assign line_ovr_val = active ? level : 1'b1;

  // R3
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && emb_en && !busy && cmd_delay != '0) |=>
      (tx_inhibit && line_ovr_en && cnt == $past(cmd_delay)));

  // R4
  brk_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && emb_en && !busy && cmd_delay != '0 && cmd_brk) |=> !line_ovr_val);

  // R5
  hold_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (busy && $stable(line_ovr_val)));

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tick) |=> (cnt == $past(cnt) - ONE));

  // R6
  count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(cnt));

  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tick && cnt == ONE) |=> (!tx_inhibit && !line_ovr_en && line_ovr_val));

  // R2
  disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!emb_en && !busy) |=> !busy);

  // R8
  zero_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && emb_en && !busy && cmd_delay == '0) |=> !tx_inhibit);

  // R7
  live_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_inhibit |-> (cnt != '0));

endmodule

// File: tb/tb_tx_delay_hold.sv
module tb_tx_delay_hold;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n, emb_en, cmd_valid, cmd_brk, tick;
  logic [W-1:0] cmd_delay;
  logic busy, tx_inhibit, line_ovr_en, line_ovr_val;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  tx_delay_hold #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .emb_en(emb_en), .cmd_valid(cmd_valid),
    .cmd_delay(cmd_delay), .cmd_brk(cmd_brk), .tick(tick), .busy(busy),
    .tx_inhibit(tx_inhibit), .line_ovr_en(line_ovr_en), .line_ovr_val(line_ovr_val)
  );

  task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {busy,inh,en,val} actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] outs();
    return {busy, tx_inhibit, line_ovr_en, line_ovr_val};
  endfunction

  function automatic logic [3:0] running(input logic brk);
    return {3'b111, ~brk};
  endfunction

  localparam logic [3:0] IDLE = 4'b0001;

  task automatic step();
    @(negedge clk);
  endtask

  task automatic run_delay(input int d, input logic brk, input int gap, input string req);
    cmd_valid = 1'b1; cmd_delay = W'(d); cmd_brk = brk; tick = 1'b1;
    step();
    cmd_valid = 1'b0; tick = 1'b0;
    if (d == 0) begin
      chk(outs(), IDLE, "R8 zero delay");
      return;
    end
    chk(outs(), running(brk), req);
    for (int k = 1; k <= d; k++) begin
      for (int g = 0; g < gap; g++) begin
        step();
        chk(outs(), running(brk), "R6 no tick holds");
      end
      tick = 1'b1;
      step();
      tick = 1'b0;
      if (k < d) chk(outs(), running(brk), brk ? "R4 break held" : "R5 fill held");
      else chk(outs(), IDLE, "R7 release");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; emb_en = 1'b0; cmd_valid = 1'b0; cmd_delay = '0; cmd_brk = 1'b0; tick = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
    chk(outs(), IDLE, "R1 reset");

    // R2: disabled channel ignores commands
    for (int d = 0; d < 16; d++) begin
      cmd_valid = 1'b1; cmd_delay = W'(d); cmd_brk = d[0];
      step();
      chk(outs(), IDLE, "R2 disabled");
    end
    cmd_valid = 1'b0;
    step();
    chk(outs(), IDLE, "R2 disabled after");

    emb_en = 1'b1;
    // R3..R8 sweep: every delay, both levels, two gap patterns
    for (int gap = 0; gap < 2; gap++)
      for (int b = 0; b < 2; b++)
        for (int d = 0; d < 16; d++)
          run_delay(d, b[0], gap, "R3 start");

    // R9: held command waits for release
    run_delay(0, 1'b0, 0, "R8 pre");
    cmd_valid = 1'b1; cmd_delay = 4'd3; cmd_brk = 1'b1;
    step();
    chk(outs(), running(1'b1), "R9 first start");
    cmd_delay = 4'd5; cmd_brk = 1'b0;
    for (int k = 1; k <= 3; k++) begin
      step();
      chk(outs(), running(1'b1), "R9 held off");
      tick = 1'b1;
      step();
      tick = 1'b0;
      if (k < 3) chk(outs(), running(1'b1), "R9 level kept");
      else chk(outs(), IDLE, "R9 first release");
    end
    step();
    cmd_valid = 1'b0;
    chk(outs(), running(1'b0), "R9 held taken");
    for (int k = 1; k <= 5; k++) begin
      tick = 1'b1;
      step();
      tick = 1'b0;
      chk(outs(), (k < 5) ? running(1'b0) : IDLE, "R9 second delay");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule